// File: doc/BRIEF.md
# Packet FIFO Fill, Transmit Start and Interrupt Routing Controller

This controller sits beside a radio packet engine's data FIFO and decides two things: when the receive path may write payload into the FIFO, and when the transmitter is told to begin sending what the host has loaded. In receive mode, writing can be enabled by the detection of a start pattern or driven directly by a configuration bit. In transmit mode, a single start pulse goes out once the FIFO holds enough data. Enough means either a programmed threshold level or simply one entry, as configured. An end-of-transmission event is raised once the FIFO and the serializer have both drained.

The same block routes internal status events to two interrupt pins. Each pin has its own select field for receive mode. In transmit mode the first pin's source follows the start-mode choice, and the second pin's source is picked by a single bit. The FIFO memory, the serializer and the signal-strength measurement are outside the block. Their status arrives on input ports.

Top module: `pkt_flow_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, fill_en, tx_start and tx_stop are all low.
- R2: In receive mode with fill_manual=0, a cycle with start_det high makes fill_en high from the next cycle on. It stays high until a cycle with data_rdy high and start_det low, after which it is low from the next cycle. In this mode fill_sw_on has no effect.
- R3: In receive mode with fill_manual=1, fill_en equals the value fill_sw_on had in the previous cycle, and start_det has no effect.
- R4: In transmit mode with tx_on_nonempty=0, tx_start is high for exactly one cycle, on the cycle after a cycle in which the controller is armed and fifo_level >= fifo_thresh.
- R5: In transmit mode with tx_on_nonempty=1, tx_start is high for exactly one cycle, on the cycle after a cycle in which the controller is armed and fifo_empty=0, whatever the level.
- R6: After a tx_start pulse, no further tx_start is issued until a tx_stop pulse or a change of mode_tx has re-armed the controller. A change of mode_tx re-arms the controller and never starts a transmission in the cycle of the change itself.
- R7: tx_stop is a one-cycle pulse, issued on the cycle after a cycle in which a transmission is active, fifo_empty=1 and tx_busy=0. tx_busy=1 holds it off, and the pulse re-arms the controller.
- R8: In receive mode, irq0 is selected by irq0_rx_sel: 0 gives data_rdy AND crc_ok, 1 gives wr_byte, 2 gives NOT fifo_empty, and 3 gives addr_match when sync_is_addr=1 or start_det when sync_is_addr=0.
- R9: In receive mode, irq1 is selected by irq1_rx_sel: 0 gives crc_ok, 1 gives fifo_full, 2 gives rssi_above AND rssi_irq_en, and 3 gives (fifo_level >= fifo_thresh).
- R10: In transmit mode, irq0 shows (fifo_level >= fifo_thresh) when tx_on_nonempty=0 and NOT fifo_empty when tx_on_nonempty=1.
- R11: In transmit mode, irq1 shows fifo_full when irq1_tx_sel=0 and tx_stop when irq1_tx_sel=1.
- R12: irq0 and irq1 switch between their receive and transmit sources in the same cycle that mode_tx changes, with no register delay.
- R13: fill_en is low on every cycle that follows a cycle with mode_tx=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_tx | input | 1 | 1 = transmit mode, 0 = receive mode |
| fill_manual | input | 1 | 1 = FIFO filling follows fill_sw_on, 0 = filling starts on start detection |
| fill_sw_on | input | 1 | Software fill control used when fill_manual=1 |
| tx_on_nonempty | input | 1 | 1 = start on FIFO not empty, 0 = start on level at or above threshold |
| irq0_rx_sel | input | 2 | Receive-mode source select for irq0 |
| irq1_rx_sel | input | 2 | Receive-mode source select for irq1 |
| irq1_tx_sel | input | 1 | Transmit-mode source select for irq1 |
| sync_is_addr | input | 1 | Makes irq0 select 3 show address match instead of start detection |
| rssi_irq_en | input | 1 | Enable for the signal-strength interrupt |
| fifo_thresh | input | LEVEL_W | FIFO level threshold |
| fifo_level | input | LEVEL_W | Current FIFO occupancy |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| start_det | input | 1 | Start pattern detected (pulse) |
| addr_match | input | 1 | Node address matched (pulse) |
| crc_ok | input | 1 | Received packet CRC is correct |
| data_rdy | input | 1 | Received packet complete |
| wr_byte | input | 1 | Pulse when a received byte is written into the FIFO |
| rssi_above | input | 1 | Signal strength is at or above its threshold |
| tx_busy | input | 1 | Serializer still shifting bits out |
| fill_en | output | 1 | Receive path may write into the FIFO |
| tx_start | output | 1 | One-cycle transmission start pulse |
| tx_stop | output | 1 | One-cycle end-of-transmission pulse |
| irq0 | output | 1 | Interrupt pin 0 |
| irq1 | output | 1 | Interrupt pin 1 |

## Verification
On every cycle, the assertions check the pulse shape and mutual exclusion of tx_start and tx_stop. They also check that tx_stop only follows an empty FIFO with an idle serializer, that tx_start only follows a cycle in transmit mode, that fill_en stays low after transmit-mode cycles, and that fill_en tracks the software bit in manual mode. The one-start-per-packet arming, the re-arming after tx_stop or a mode change, the threshold versus not-empty start choices, and every interrupt source encoding can only be shown by the bench's directed scenarios. Each of these needs a specific sequence of inputs and a known expected value.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        IRQ0_RX_CRC_RDY  = 2'd0,
        IRQ0_RX_WR_BYTE  = 2'd1,
        IRQ0_RX_NOTEMPTY = 2'd2,
        IRQ0_RX_SYNC     = 2'd3
    } irq0_rx_sel_e;

    typedef enum logic [1:0] {
        IRQ1_RX_CRC_OK = 2'd0,
        IRQ1_RX_FULL   = 2'd1,
        IRQ1_RX_RSSI   = 2'd2,
        IRQ1_RX_THRESH = 2'd3
    } irq1_rx_sel_e;

    typedef struct packed {
        logic fill;
    } fill_state_t;

    typedef struct packed {
        logic armed;
        logic active;
        logic start;
        logic stop;
        logic mode;
    } tx_state_t;

endpackage

// File: rtl/pfc_fill_ctrl.sv
module pfc_fill_ctrl
    import pfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_tx,
    input  logic manual,
    input  logic sw_on,
    input  logic start_det,
    input  logic pkt_done,
    output logic fill_en
);

    fill_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (mode_tx) begin
            state_d.fill = 1'b0;
        end else if (manual) begin
            state_d.fill = sw_on;
        end else if (start_det) begin
            state_d.fill = 1'b1;
        end else if (pkt_done) begin
            state_d.fill = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign fill_en = state_q.fill;

    // R13: no filling after a transmit-mode cycle
    assert_no_fill_in_tx_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mode_tx |=> !fill_en);

    // R3: manual mode follows the software bit
    assert_manual_follows_sw_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_tx && manual) |=> (fill_en == $past(sw_on)));

    // R2: in automatic mode filling only begins after a start detection
    assert_auto_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_tx && !manual && !start_det && !fill_en) |=> !fill_en);

endmodule

// File: rtl/pfc_tx_ctrl.sv
module pfc_tx_ctrl
    import pfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_tx,
    input  logic on_nonempty,
    input  logic thresh_hit,
    input  logic fifo_empty,
    input  logic shift_busy,
    output logic tx_start,
    output logic tx_stop
);

    tx_state_t state_d, state_q;
    logic      mode_changed;
    logic      start_cond;
    logic      drained;

    always_comb begin
        mode_changed = (mode_tx != state_q.mode);
        start_cond   = on_nonempty ? !fifo_empty : thresh_hit;
        drained      = state_q.active && fifo_empty && !shift_busy;

        state_d       = state_q;
        state_d.mode  = mode_tx;
        state_d.start = 1'b0;
        state_d.stop  = 1'b0;

        if (mode_changed) begin
            state_d.armed  = 1'b1;
            state_d.active = 1'b0;
        end else if (mode_tx) begin
            if (drained) begin
                state_d.stop   = 1'b1;
                state_d.active = 1'b0;
                state_d.armed  = 1'b1;
            end else if (state_q.armed && start_cond) begin
                state_d.start  = 1'b1;
                state_d.active = 1'b1;
                state_d.armed  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_start = state_q.start;
    assign tx_stop  = state_q.stop;

    // R4: start is a single-cycle pulse
    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R7: stop is a single-cycle pulse
    assert_stop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop |=> !tx_stop);

    // R7: stop only after an empty FIFO with an idle serializer
    assert_stop_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_stop) |-> ($past(fifo_empty) && !$past(shift_busy) && $past(mode_tx)));

    // R6: start only follows a transmit-mode cycle
    assert_start_in_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_start) |-> $past(mode_tx));

    // R6: start and stop never coincide
    assert_start_stop_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_start && tx_stop));

endmodule

// File: rtl/pfc_irq_route.sv
module pfc_irq_route
    import pfc_pkg::*;
(
    input  logic       mode_tx,
    input  logic [1:0] irq0_rx_sel,
    input  logic [1:0] irq1_rx_sel,
    input  logic       irq1_tx_sel,
    input  logic       tx_on_nonempty,
    input  logic       sync_is_addr,
    input  logic       rssi_irq_en,
    input  logic       thresh_hit,
    input  logic       fifo_full,
    input  logic       fifo_empty,
    input  logic       start_det,
    input  logic       addr_match,
    input  logic       crc_ok,
    input  logic       data_rdy,
    input  logic       wr_byte,
    input  logic       rssi_above,
    input  logic       tx_stop,
    output logic       irq0,
    output logic       irq1
);

    logic rx_irq0, rx_irq1, tx_irq0, tx_irq1;
    logic rssi_irq;

    always_comb begin
        rssi_irq = rssi_above && rssi_irq_en;

        unique case (irq0_rx_sel_e'(irq0_rx_sel))
            IRQ0_RX_CRC_RDY:  rx_irq0 = data_rdy && crc_ok;
            IRQ0_RX_WR_BYTE:  rx_irq0 = wr_byte;
            IRQ0_RX_NOTEMPTY: rx_irq0 = !fifo_empty;
            IRQ0_RX_SYNC:     rx_irq0 = sync_is_addr ? addr_match : start_det;
            default:          rx_irq0 = 1'b0;
        endcase

        unique case (irq1_rx_sel_e'(irq1_rx_sel))
            IRQ1_RX_CRC_OK: rx_irq1 = crc_ok;
            IRQ1_RX_FULL:   rx_irq1 = fifo_full;
            IRQ1_RX_RSSI:   rx_irq1 = rssi_irq;
            IRQ1_RX_THRESH: rx_irq1 = thresh_hit;
            default:        rx_irq1 = 1'b0;
        endcase

        tx_irq0 = tx_on_nonempty ? !fifo_empty : thresh_hit;
        tx_irq1 = irq1_tx_sel ? tx_stop : fifo_full;

        irq0 = mode_tx ? tx_irq0 : rx_irq0;
        irq1 = mode_tx ? tx_irq1 : rx_irq1;
    end

endmodule

// File: rtl/pkt_flow_ctrl.sv
module pkt_flow_ctrl #(
    parameter  int FIFO_DEPTH = 64,
    localparam int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_tx,
    input  logic               fill_manual,
    input  logic               fill_sw_on,
    input  logic               tx_on_nonempty,
    input  logic [1:0]         irq0_rx_sel,
    input  logic [1:0]         irq1_rx_sel,
    input  logic               irq1_tx_sel,
    input  logic               sync_is_addr,
    input  logic               rssi_irq_en,
    input  logic [LEVEL_W-1:0] fifo_thresh,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               fifo_full,
    input  logic               fifo_empty,
    input  logic               start_det,
    input  logic               addr_match,
    input  logic               crc_ok,
    input  logic               data_rdy,
    input  logic               wr_byte,
    input  logic               rssi_above,
    input  logic               tx_busy,
    output logic               fill_en,
    output logic               tx_start,
    output logic               tx_stop,
    output logic               irq0,
    output logic               irq1
);

    logic thresh_hit;

    assign thresh_hit = (fifo_level >= fifo_thresh);

    pfc_fill_ctrl u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_tx   (mode_tx),
        .manual    (fill_manual),
        .sw_on     (fill_sw_on),
        .start_det (start_det),
        .pkt_done  (data_rdy),
        .fill_en   (fill_en)
    );

    pfc_tx_ctrl u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_tx     (mode_tx),
        .on_nonempty (tx_on_nonempty),
        .thresh_hit  (thresh_hit),
        .fifo_empty  (fifo_empty),
        .shift_busy  (tx_busy),
        .tx_start    (tx_start),
        .tx_stop     (tx_stop)
    );

    pfc_irq_route u_irq (
        .mode_tx        (mode_tx),
        .irq0_rx_sel    (irq0_rx_sel),
        .irq1_rx_sel    (irq1_rx_sel),
        .irq1_tx_sel    (irq1_tx_sel),
        .tx_on_nonempty (tx_on_nonempty),
        .sync_is_addr   (sync_is_addr),
        .rssi_irq_en    (rssi_irq_en),
        .thresh_hit     (thresh_hit),
        .fifo_full      (fifo_full),
        .fifo_empty     (fifo_empty),
        .start_det      (start_det),
        .addr_match     (addr_match),
        .crc_ok         (crc_ok),
        .data_rdy       (data_rdy),
        .wr_byte        (wr_byte),
        .rssi_above     (rssi_above),
        .tx_stop        (tx_stop),
        .irq0           (irq0),
        .irq1           (irq1)
    );

    // R1: outputs quiet on the first cycle after reset release
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!fill_en && !tx_start && !tx_stop));

endmodule

// File: tb/pkt_flow_ctrl_tb.sv
module pkt_flow_ctrl_tb;

    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_tx = 1'b0;
    logic          fill_manual = 1'b0;
    logic          fill_sw_on = 1'b0;
    logic          tx_on_nonempty = 1'b0;
    logic [1:0]    irq0_rx_sel = 2'd0;
    logic [1:0]    irq1_rx_sel = 2'd0;
    logic          irq1_tx_sel = 1'b0;
    logic          sync_is_addr = 1'b0;
    logic          rssi_irq_en = 1'b0;
    logic [LW-1:0] fifo_thresh = 7'd8;
    logic [LW-1:0] fifo_level = 7'd0;
    logic          fifo_full = 1'b0;
    logic          fifo_empty = 1'b1;
    logic          start_det = 1'b0;
    logic          addr_match = 1'b0;
    logic          crc_ok = 1'b0;
    logic          data_rdy = 1'b0;
    logic          wr_byte = 1'b0;
    logic          rssi_above = 1'b0;
    logic          tx_busy = 1'b0;
    logic          fill_en, tx_start, tx_stop, irq0, irq1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pkt_flow_ctrl #(.FIFO_DEPTH(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_tx(mode_tx), .fill_manual(fill_manual),
        .fill_sw_on(fill_sw_on), .tx_on_nonempty(tx_on_nonempty),
        .irq0_rx_sel(irq0_rx_sel), .irq1_rx_sel(irq1_rx_sel), .irq1_tx_sel(irq1_tx_sel),
        .sync_is_addr(sync_is_addr), .rssi_irq_en(rssi_irq_en), .fifo_thresh(fifo_thresh),
        .fifo_level(fifo_level), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .start_det(start_det), .addr_match(addr_match), .crc_ok(crc_ok),
        .data_rdy(data_rdy), .wr_byte(wr_byte), .rssi_above(rssi_above),
        .tx_busy(tx_busy), .fill_en(fill_en), .tx_start(tx_start), .tx_stop(tx_stop),
        .irq0(irq0), .irq1(irq1)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FIFO check FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick();
        chk("R1 fill_en in reset", fill_en, 1'b0);
        chk("R1 tx_start in reset", tx_start, 1'b0);
        chk("R1 tx_stop in reset", tx_stop, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 fill_en after reset", fill_en, 1'b0);
        chk("R1 tx_stop after reset", tx_stop, 1'b0);
    endtask

    task automatic t_auto_fill();
        mode_tx = 1'b0; fill_manual = 1'b0; fill_sw_on = 1'b1;
        tick();
        chk("R2 sw_on ignored in auto", fill_en, 1'b0);
        start_det = 1'b1;
        tick();
        start_det = 1'b0;
        chk("R2 fill on start detect", fill_en, 1'b1);
        tick();
        chk("R2 fill held", fill_en, 1'b1);
        data_rdy = 1'b1;
        tick();
        data_rdy = 1'b0;
        chk("R2 fill cleared on packet end", fill_en, 1'b0);
        fill_sw_on = 1'b0;
    endtask

    task automatic t_manual_fill();
        mode_tx = 1'b0; fill_manual = 1'b1; fill_sw_on = 1'b0; start_det = 1'b1;
        tick();
        start_det = 1'b0;
        chk("R3 start_det ignored in manual", fill_en, 1'b0);
        fill_sw_on = 1'b1;
        tick();
        chk("R3 fill follows sw on", fill_en, 1'b1);
        fill_sw_on = 1'b0;
        tick();
        chk("R3 fill follows sw off", fill_en, 1'b0);
        fill_sw_on = 1'b1;
        tick();
        mode_tx = 1'b1;
        tick();
        chk("R13 fill low in tx", fill_en, 1'b0);
        mode_tx = 1'b0; fill_manual = 1'b0; fill_sw_on = 1'b0;
        tick();
        tick();
    endtask

    task automatic t_tx_threshold();
        tx_on_nonempty = 1'b0; fifo_thresh = 7'd8; irq1_tx_sel = 1'b1;
        fifo_level = 7'd5; fifo_empty = 1'b0;
        mode_tx = 1'b1;
        tick();
        chk("R6 no start on mode change cycle", tx_start, 1'b0);
        tick();
        chk("R4 below threshold no start", tx_start, 1'b0);
        fifo_level = 7'd8;
        tick();
        chk("R4 start at threshold", tx_start, 1'b1);
        tick();
        chk("R4 start one cycle", tx_start, 1'b0);
        tick();
        chk("R6 no second start", tx_start, 1'b0);
        tx_busy = 1'b1; fifo_level = 7'd0; fifo_empty = 1'b1;
        tick();
        chk("R7 stop held while busy", tx_stop, 1'b0);
        tx_busy = 1'b0;
        tick();
        chk("R7 stop after drain", tx_stop, 1'b1);
        chk("R11 irq1 shows tx_stop", irq1, 1'b1);
        tick();
        chk("R7 stop one cycle", tx_stop, 1'b0);
        chk("R11 irq1 follows tx_stop low", irq1, 1'b0);
        fifo_level = 7'd9; fifo_empty = 1'b0;
        tick();
        chk("R7 re-armed after stop", tx_start, 1'b1);
        tick();
    endtask

    task automatic t_tx_nonempty();
        tx_on_nonempty = 1'b1; fifo_thresh = 7'd8;
        fifo_level = 7'd0; fifo_empty = 1'b1;
        mode_tx = 1'b0;
        tick();
        mode_tx = 1'b1;
        tick();
        tick();
        chk("R5 empty no start", tx_start, 1'b0);
        fifo_level = 7'd1; fifo_empty = 1'b0;
        tick();
        chk("R5 start on not empty", tx_start, 1'b1);
        tick();
        chk("R5 start one cycle", tx_start, 1'b0);
        mode_tx = 1'b0;
        tick();
        mode_tx = 1'b1;
        tick();
        chk("R6 mode change cycle no start", tx_start, 1'b0);
        tick();
        chk("R6 re-armed by mode change", tx_start, 1'b1);
        tick();
        mode_tx = 1'b0; fifo_level = 7'd0; fifo_empty = 1'b1;
        tick();
    endtask

    task automatic t_irq_rx();
        mode_tx = 1'b0;
        irq0_rx_sel = 2'd0; data_rdy = 1'b1; crc_ok = 1'b0; settle();
        chk("R8 sel0 crc bad", irq0, 1'b0);
        crc_ok = 1'b1; settle();
        chk("R8 sel0 ready and crc ok", irq0, 1'b1);
        data_rdy = 1'b0; crc_ok = 1'b0;
        irq0_rx_sel = 2'd1; wr_byte = 1'b1; settle();
        chk("R8 sel1 write byte", irq0, 1'b1);
        wr_byte = 1'b0;
        irq0_rx_sel = 2'd2; fifo_empty = 1'b1; settle();
        chk("R8 sel2 empty", irq0, 1'b0);
        fifo_empty = 1'b0; settle();
        chk("R8 sel2 not empty", irq0, 1'b1);
        fifo_empty = 1'b1;
        irq0_rx_sel = 2'd3; sync_is_addr = 1'b0; start_det = 1'b0; addr_match = 1'b1; settle();
        chk("R8 sel3 start mode ignores addr", irq0, 1'b0);
        sync_is_addr = 1'b1; settle();
        chk("R8 sel3 address match", irq0, 1'b1);
        addr_match = 1'b0; sync_is_addr = 1'b0;
        irq1_rx_sel = 2'd0; crc_ok = 1'b1; settle();
        chk("R9 sel0 crc ok", irq1, 1'b1);
        crc_ok = 1'b0;
        irq1_rx_sel = 2'd1; fifo_full = 1'b1; settle();
        chk("R9 sel1 full", irq1, 1'b1);
        fifo_full = 1'b0;
        irq1_rx_sel = 2'd2; rssi_above = 1'b1; rssi_irq_en = 1'b0; settle();
        chk("R9 sel2 rssi disabled", irq1, 1'b0);
        rssi_irq_en = 1'b1; settle();
        chk("R9 sel2 rssi enabled", irq1, 1'b1);
        rssi_above = 1'b0; settle();
        chk("R9 sel2 rssi below", irq1, 1'b0);
        irq1_rx_sel = 2'd3; fifo_thresh = 7'd4; fifo_level = 7'd3; settle();
        chk("R9 sel3 below threshold", irq1, 1'b0);
        fifo_level = 7'd4; settle();
        chk("R9 sel3 at threshold", irq1, 1'b1);
    endtask

    task automatic t_irq_tx();
        fifo_thresh = 7'd10; fifo_level = 7'd3; fifo_empty = 1'b0; fifo_full = 1'b1;
        irq1_rx_sel = 2'd0; crc_ok = 1'b0; irq1_tx_sel = 1'b0;
        irq0_rx_sel = 2'd1; wr_byte = 1'b0;
        tx_on_nonempty = 1'b0; mode_tx = 1'b0; settle();
        chk("R12 rx irq0 before switch", irq0, 1'b0);
        mode_tx = 1'b1; settle();
        chk("R10 threshold source below", irq0, 1'b0);
        chk("R11 irq1 shows full", irq1, 1'b1);
        tx_on_nonempty = 1'b1; settle();
        chk("R10 not empty source", irq0, 1'b1);
        chk("R12 irq0 switched with mode", irq0, 1'b1);
        mode_tx = 1'b0; settle();
        chk("R12 irq1 back to rx crc source", irq1, 1'b0);
        fifo_full = 1'b0; fifo_empty = 1'b1; fifo_level = 7'd0;
        tick();
    endtask

    initial begin
        t_reset();
        t_auto_fill();
        t_manual_fill();
        t_tx_threshold();
        t_tx_nonempty();
        t_irq_rx();
        t_irq_tx();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("Watchdog FAIL all: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule